// File: doc/BRIEF.md
# Multi-Region SRAM Wait-State Controller

This block stands between a processor's memory request port and a set of on-chip SRAM regions. Each request address is decoded into one of four regions. The block then holds off completion for a number of cycles that is programmed separately for reads and for writes in that region. An address outside every region completes at once and is flagged as a decode error. The RAM arrays, bus arbitration and error checking all sit elsewhere.

The wait counts are set through a configuration port. That port reaches two registers. The first is a protect register. Its key byte opens or closes write access to the second, the wait-count register. One write to the wait-count register carries a region mask plus a read count and a write count. Every region whose mask bit is set takes both counts. A requester raises `req_valid`, holds its address and direction steady, and waits until it sees `req_ready` high.

Top module: `sram_wait_ctrl`

## Requirements
- R1: Address ranges are inclusive. Mask bit 0 selects the main region, 0x20000000 to 0x20057FFF. Bit 1 selects the upper region, 0x20058000 to 0x2005FFFF. Bit 2 selects the high-alias region, 0x1FFE0000 to 0x1FFFFFFF. Bit 3 selects the backup region, 0x200F0000 to 0x200F0FFF. Each access uses only the counts of the region that holds its address.
- R2: An address outside every region completes with `req_ready` high in its acceptance cycle, with `req_decerr` high in that same cycle. `req_decerr` is never high at any other time.
- R3: A request is accepted in the first cycle that `req_valid` is high while the block is idle. With a count of N, `req_ready` stays low for N cycles starting at acceptance and goes high in the cycle after those N. With N = 0, `req_ready` is high in the acceptance cycle.
- R4: `req_write` high uses the region's write count. `req_write` low uses its read count.
- R5: A wait-count write (`cfg_prot_sel` low) carries the region mask in bits 3:0, the read count in bits 6:4 and the write count in bits 10:8. Every masked region takes both counts. Unmasked regions keep their counts. Any number of mask bits may be set.
- R6: A protect write (`cfg_prot_sel` high) unlocks when bits 7:0 are 0x77 and locks when they are 0x76. Any other value leaves the lock state as it was.
- R7: While the block is locked, wait-count writes are ignored and every count stays unchanged.
- R8: After reset the block is locked, all counts are 0 and `req_ready` is low while no request is present.
- R9: The count is fixed at acceptance. A wait-count write in the acceptance cycle, or during the wait, first affects the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 32 | Request byte address |
| req_ready | output | 1 | Access completes in this cycle |
| req_decerr | output | 1 | Address matched no region (only with `req_ready`) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_prot_sel | input | 1 | 1 = protect register, 0 = wait-count register |
| cfg_wdata | input | 16 | Configuration write data |

## Verification
A configuration write and a request acceptance can fall in the same cycle. A configuration write can also land while a wait is still counting. The bench provokes both cases. It raises `req_valid` and `cfg_we` together on one edge. It also sends a reprogramming write two cycles into a seven-cycle stall. A behavioural model keeps the old count for the request already in flight and applies the new one only from the next request. It compares `req_ready` and `req_decerr` with the design on every clock, so a completion one cycle early or late is reported.

// File: rtl/sram_wait_pkg.sv
package sram_wait_pkg;

   localparam int unsigned DEF_NUM_RGN = 4;
   localparam int unsigned DEF_ADDR_W  = 32;

   // index order is the region-mask bit order
   localparam logic [DEF_NUM_RGN-1:0][DEF_ADDR_W-1:0] DEF_RGN_BASE = {
      32'h200F_0000,   // bit 3: backup region
      32'h1FFE_0000,   // bit 2: high-alias region
      32'h2005_8000,   // bit 1: upper region
      32'h2000_0000    // bit 0: main region
   };
   localparam logic [DEF_NUM_RGN-1:0][DEF_ADDR_W-1:0] DEF_RGN_LIMIT = {
      32'h200F_0FFF,
      32'h1FFF_FFFF,
      32'h2005_FFFF,
      32'h2005_7FFF
   };

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_WAIT = 1'b1
   } seq_state_e;

endpackage

// File: rtl/sram_rgn_decode.sv
module sram_rgn_decode #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned NUM_RGN = 4,
   parameter int unsigned IDX_W   = 2,
   parameter logic [NUM_RGN-1:0][ADDR_W-1:0] RGN_BASE  = '0,
   parameter logic [NUM_RGN-1:0][ADDR_W-1:0] RGN_LIMIT = '0
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NUM_RGN-1:0] hit_vec,
   output logic               hit_any,
   output logic [IDX_W-1:0]   hit_idx
);

   for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
      if (RGN_BASE[g] > RGN_LIMIT[g]) begin : g_bad_range
         $error("sram_rgn_decode: region base above its limit");
      end
      assign hit_vec[g] = (addr >= RGN_BASE[g]) && (addr <= RGN_LIMIT[g]);
   end

   assign hit_any = |hit_vec;

   always_comb begin
      hit_idx = '0;
      for (int i = NUM_RGN - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/sram_wait_cfg.sv
module sram_wait_cfg #(
   parameter int unsigned NUM_RGN = 4,
   parameter int unsigned WAIT_W  = 3,
   parameter int unsigned CFG_W   = 16,
   parameter int unsigned KEY_W   = 8,
   parameter int unsigned RD_LSB  = 4,
   parameter int unsigned WR_LSB  = 8,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 8'h77,
   parameter logic [KEY_W-1:0] LOCK_KEY   = 8'h76
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic                            cfg_prot_sel,
   input  logic [CFG_W-1:0]                cfg_wdata,
   output logic                            locked,
   output logic [NUM_RGN-1:0][WAIT_W-1:0]  rd_wait,
   output logic [NUM_RGN-1:0][WAIT_W-1:0]  wr_wait
);

   logic              prot_we;
   logic              wait_we;
   logic [KEY_W-1:0]  key;
   logic [WAIT_W-1:0] new_rd;
   logic [WAIT_W-1:0] new_wr;
   logic              unused_cfg;

   assign key        = cfg_wdata[KEY_W-1:0];
   assign new_rd     = cfg_wdata[RD_LSB +: WAIT_W];
   assign new_wr     = cfg_wdata[WR_LSB +: WAIT_W];
   assign prot_we    = cfg_we && cfg_prot_sel;
   assign wait_we    = cfg_we && !cfg_prot_sel && !locked;
   assign unused_cfg = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b1;
      end else if (prot_we) begin
         if (key == UNLOCK_KEY)    locked <= 1'b0;
         else if (key == LOCK_KEY) locked <= 1'b1;
      end
   end

   for (genvar g = 0; g < NUM_RGN; g++) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_wait[g] <= '0;
            wr_wait[g] <= '0;
         end else if (wait_we && cfg_wdata[g]) begin
            rd_wait[g] <= new_rd;
            wr_wait[g] <= new_wr;
         end
      end
   end

endmodule

// File: rtl/sram_wait_seq.sv
module sram_wait_seq #(
   parameter int unsigned WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              miss,
   input  logic [WAIT_W-1:0] wait_n,
   output logic              req_ready,
   output logic              req_decerr,
   output logic              busy
);
   import sram_wait_pkg::*;

   seq_state_e        state;
   logic [WAIT_W-1:0] remain;

   assign busy = (state == SEQ_WAIT);

   always_comb begin
      req_ready  = 1'b0;
      req_decerr = 1'b0;
      if (state == SEQ_IDLE) begin
         req_ready  = req_valid && (wait_n == '0);
         req_decerr = req_valid && miss;
      end else begin
         req_ready  = (remain == '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         remain <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (req_valid && (wait_n != '0)) begin
                  state  <= SEQ_WAIT;
                  remain <= wait_n - 1'b1;
               end
            end
            SEQ_WAIT: begin
               if (remain == '0) state <= SEQ_IDLE;
               else              remain <= remain - 1'b1;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sram_wait_ctrl.sv
module sram_wait_ctrl #(
   parameter int unsigned ADDR_W  = sram_wait_pkg::DEF_ADDR_W,
   parameter int unsigned NUM_RGN = sram_wait_pkg::DEF_NUM_RGN,
   parameter int unsigned WAIT_W  = 3,
   parameter int unsigned CFG_W   = 16,
   parameter int unsigned KEY_W   = 8,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 8'h77,
   parameter logic [KEY_W-1:0] LOCK_KEY   = 8'h76,
   parameter logic [NUM_RGN-1:0][ADDR_W-1:0] RGN_BASE  = sram_wait_pkg::DEF_RGN_BASE,
   parameter logic [NUM_RGN-1:0][ADDR_W-1:0] RGN_LIMIT = sram_wait_pkg::DEF_RGN_LIMIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              req_decerr,
   input  logic              cfg_we,
   input  logic              cfg_prot_sel,
   input  logic [CFG_W-1:0]  cfg_wdata
);

   localparam int unsigned IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;
   localparam int unsigned RD_LSB = ((NUM_RGN + 3) / 4) * 4;
   localparam int unsigned WR_LSB = RD_LSB + ((WAIT_W + 3) / 4) * 4;

   if (WAIT_W < 1 || WAIT_W > 4) begin : g_bad_wait_w
      $error("sram_wait_ctrl: WAIT_W must be 1..4");
   end
   if (WR_LSB + WAIT_W > CFG_W || KEY_W > CFG_W) begin : g_bad_cfg_w
      $error("sram_wait_ctrl: CFG_W too narrow for its fields");
   end
   if (NUM_RGN < 1) begin : g_bad_nrgn
      $error("sram_wait_ctrl: need at least one region");
   end

   logic [NUM_RGN-1:0]             hit_vec;
   logic                           hit_any;
   logic [IDX_W-1:0]               hit_idx;
   logic                           locked;
   logic [NUM_RGN-1:0][WAIT_W-1:0] rd_wait;
   logic [NUM_RGN-1:0][WAIT_W-1:0] wr_wait;
   logic [WAIT_W-1:0]              sel_wait;
   logic                           busy;

   sram_rgn_decode #(
      .ADDR_W(ADDR_W), .NUM_RGN(NUM_RGN), .IDX_W(IDX_W),
      .RGN_BASE(RGN_BASE), .RGN_LIMIT(RGN_LIMIT)
   ) u_decode (
      .addr(req_addr), .hit_vec(hit_vec), .hit_any(hit_any), .hit_idx(hit_idx)
   );

   sram_wait_cfg #(
      .NUM_RGN(NUM_RGN), .WAIT_W(WAIT_W), .CFG_W(CFG_W), .KEY_W(KEY_W),
      .RD_LSB(RD_LSB), .WR_LSB(WR_LSB),
      .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prot_sel(cfg_prot_sel),
      .cfg_wdata(cfg_wdata), .locked(locked), .rd_wait(rd_wait), .wr_wait(wr_wait)
   );

   always_comb begin
      sel_wait = '0;
      if (hit_any) sel_wait = req_write ? wr_wait[hit_idx] : rd_wait[hit_idx];
   end

   sram_wait_seq #(.WAIT_W(WAIT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .miss(!hit_any),
      .wait_n(sel_wait), .req_ready(req_ready), .req_decerr(req_decerr), .busy(busy)
   );

endmodule

// File: rtl/sram_wait_chk.sv
module sram_wait_chk #(
   parameter int unsigned NUM_RGN = 4,
   parameter int unsigned WAIT_W  = 3,
   parameter int unsigned CFG_W   = 16,
   parameter int unsigned KEY_W   = 8,
   parameter logic [KEY_W-1:0] UNLOCK_KEY = 8'h77,
   parameter logic [KEY_W-1:0] LOCK_KEY   = 8'h76
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           req_valid,
   input logic                           req_ready,
   input logic                           req_decerr,
   input logic                           cfg_we,
   input logic                           cfg_prot_sel,
   input logic [CFG_W-1:0]               cfg_wdata,
   input logic                           locked,
   input logic [NUM_RGN-1:0][WAIT_W-1:0] rd_wait,
   input logic [NUM_RGN-1:0][WAIT_W-1:0] wr_wait,
   input logic [NUM_RGN-1:0]             hit_vec
);

   localparam int unsigned MAX_WAIT = (1 << WAIT_W) - 1;

   logic [WAIT_W:0] stall_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        stall_cnt <= '0;
      else if (req_valid && !req_ready)  stall_cnt <= stall_cnt + 1'b1;
      else                               stall_cnt <= '0;
   end

   p_hit_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   p_decerr_with_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_decerr |-> req_ready);

   p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> req_valid);

   p_stall_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stall_cnt <= (WAIT_W+1)'(MAX_WAIT));

   p_no_write_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(rd_wait) && $stable(wr_wait));

   p_unlock_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_prot_sel && (cfg_wdata[KEY_W-1:0] == UNLOCK_KEY) |=> !locked);

   p_lock_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && cfg_prot_sel && (cfg_wdata[KEY_W-1:0] == LOCK_KEY) |=> locked);

   p_locked_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !cfg_prot_sel && locked |=> $stable(rd_wait) && $stable(wr_wait));

endmodule

bind sram_wait_ctrl sram_wait_chk #(
   .NUM_RGN(NUM_RGN), .WAIT_W(WAIT_W), .CFG_W(CFG_W), .KEY_W(KEY_W),
   .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_decerr(req_decerr), .cfg_we(cfg_we), .cfg_prot_sel(cfg_prot_sel),
   .cfg_wdata(cfg_wdata), .locked(locked), .rd_wait(rd_wait),
   .wr_wait(wr_wait), .hit_vec(hit_vec)
);

// File: tb/test_sram_wait_ctrl.sv
`timescale 1ns/1ps
module test_sram_wait_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready;
   logic        req_decerr;
   logic        cfg_we = 1'b0;
   logic        cfg_prot_sel = 1'b0;
   logic [15:0] cfg_wdata = '0;

   int    checks = 0;
   int    fails = 0;
   int    cyc = 0;
   string tag = "R8";

   // behavioural model state
   int m_rd[4];
   int m_wr[4];
   bit m_locked;
   bit m_busy;
   int m_rem;

   always #4 clk = ~clk;

   sram_wait_ctrl i_sram_wait_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_ready(req_ready), .req_decerr(req_decerr),
      .cfg_we(cfg_we), .cfg_prot_sel(cfg_prot_sel), .cfg_wdata(cfg_wdata)
   );

   // R1 region map, mask-bit numbering
   function automatic int region_of(input logic [31:0] a);
      if (a >= 32'h2000_0000 && a <= 32'h2005_7FFF) return 0;
      if (a >= 32'h2005_8000 && a <= 32'h2005_FFFF) return 1;
      if (a >= 32'h1FFE_0000 && a <= 32'h1FFF_FFFF) return 2;
      if (a >= 32'h200F_0000 && a <= 32'h200F_0FFF) return 3;
      return -1;
   endfunction

   // R5 field layout: mask 3:0, read 6:4, write 10:8
   function automatic logic [15:0] wait_word(input int mask, input int rd, input int wr);
      return 16'(mask & 15) | (16'(rd & 7) << 4) | (16'(wr & 7) << 8);
   endfunction

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(negedge clk) begin
      int  r;
      int  n;
      bit  er;
      bit  ed;
      if (!rst_n) begin
         m_locked = 1'b1;
         m_busy   = 1'b0;
         m_rem    = 0;
         for (int i = 0; i < 4; i++) begin m_rd[i] = 0; m_wr[i] = 0; end
      end else begin
         er = 1'b0; ed = 1'b0; n = 0;
         if (m_busy) begin
            er = (m_rem == 0);
         end else if (req_valid) begin
            r = region_of(req_addr);
            if (r >= 0) n = req_write ? m_wr[r] : m_rd[r];
            er = (n == 0);
            ed = (r < 0);
         end
         checks++;
         if (req_ready !== er || req_decerr !== ed) begin
            fails++;
            $display("FAIL %s: addr %h write %b ready/decerr actual %b/%b expected %b/%b",
                     tag, req_addr, req_write, req_ready, req_decerr, er, ed);
         end
         // state for the coming edge
         if (m_busy) begin
            if (m_rem == 0) m_busy = 1'b0;
            else            m_rem--;
         end else if (req_valid && n > 0) begin
            m_busy = 1'b1;
            m_rem  = n - 1;
         end
         if (cfg_we) begin
            if (cfg_prot_sel) begin
               if (cfg_wdata[7:0] == 8'h77)      m_locked = 1'b0;
               else if (cfg_wdata[7:0] == 8'h76) m_locked = 1'b1;
            end else if (!m_locked) begin
               for (int i = 0; i < 4; i++) begin
                  if (cfg_wdata[i]) begin
                     m_rd[i] = int'(cfg_wdata[6:4]);
                     m_wr[i] = int'(cfg_wdata[10:8]);
                  end
               end
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL R3: watchdog, actual still running, expected done");
         finish_up();
      end
   end

   // tasks start and end one time unit after a rising edge
   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic access(input logic [31:0] a, input logic w);
      req_valid = 1'b1; req_write = w; req_addr = a;
      forever begin
         @(negedge clk);
         if (req_ready) break;
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic cfg_write(input logic prot, input logic [15:0] d);
      cfg_we = 1'b1; cfg_prot_sel = prot; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic sweep();
      logic [31:0] pts[8] = '{32'h1FFE_0000, 32'h1FFF_FFFF, 32'h2000_0000, 32'h2005_7FFF,
                              32'h2005_8000, 32'h2005_FFFF, 32'h200F_0000, 32'h200F_0FFF};
      for (int i = 0; i < 8; i++) begin
         access(pts[i], 1'b0); step(1);
         access(pts[i], 1'b1); step(1);
      end
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      // R8: idle, nothing requested, ready low
      @(negedge clk);
      checks++;
      if (req_ready !== 1'b0 || req_decerr !== 1'b0) begin
         fails++;
         $display("FAIL R8: idle ready/decerr actual %b/%b expected 0/0", req_ready, req_decerr);
      end
      @(posedge clk); #1;

      tag = "R8"; sweep();                                  // all counts zero after reset
      tag = "R7"; cfg_write(1'b0, wait_word(15, 5, 3)); step(1); sweep();
      tag = "R6"; cfg_write(1'b1, 16'h0055); cfg_write(1'b0, wait_word(15, 6, 6)); sweep();
      tag = "R6"; cfg_write(1'b1, 16'h0077);
      tag = "R5";
      cfg_write(1'b0, wait_word(1, 2, 5));
      cfg_write(1'b0, wait_word(6, 7, 1));
      cfg_write(1'b0, wait_word(8, 0, 4));
      tag = "R4"; sweep();
      tag = "R1"; sweep();
      tag = "R2";
      access(32'h1FFD_FFFF, 1'b0); access(32'h2006_0000, 1'b1);
      access(32'h200E_FFFF, 1'b0); access(32'h200F_1000, 1'b1);
      access(32'h0000_0000, 1'b0);
      tag = "R3";
      access(32'h2000_0100, 1'b0); access(32'h2005_9000, 1'b1);  // back to back
      access(32'h200F_0010, 1'b0); access(32'h200F_0010, 1'b1);
      // R9: configuration write in the acceptance cycle
      tag = "R9";
      fork
         access(32'h2005_A000, 1'b0);
         cfg_write(1'b0, wait_word(2, 3, 2));
      join
      step(1);
      access(32'h2005_A000, 1'b0);
      // R9: configuration write during a seven-cycle stall
      fork
         access(32'h1FFF_0000, 1'b0);
         begin step(2); cfg_write(1'b0, wait_word(4, 1, 1)); end
      join
      access(32'h1FFF_0000, 1'b0);
      // R6/R7: lock again and confirm writes are ignored
      tag = "R7";
      cfg_write(1'b1, 16'h0076);
      cfg_write(1'b0, wait_word(15, 0, 0));
      sweep();
      tag = "R6";
      cfg_write(1'b1, 16'h0077);
      cfg_write(1'b0, wait_word(15, 0, 0));
      sweep();
      step(4);
      finish_up();
   end

endmodule